// File: doc/BRIEF.md
# Six-Input Stacking Bit Counter

This block counts how many of six single-bit inputs are high and returns the result as a 3-bit unsigned number. It does not use a full-adder tree. The inputs are split into two groups of three. Each group is sorted into a small thermometer stack, with every one packed toward bit 0. The two stacks are then merged into a single 6-bit thermometer stack. A short decoder turns that stack into binary. Every gate from an input to a count bit is an AND, an OR or an inverter, so no exclusive-OR gate sits on the path.

The counting logic is purely combinational. A thin wrapper puts it between a qualifying strobe and one output register stage, so the block can sit in a timed pipeline. When the strobe is low, the register holds its previous result. The merged stack is brought out next to the count so that a downstream compressor can use the thermometer form directly.

Top module: `stack_popcnt6_reg`

## Requirements
- R1: While reset is asserted and before any strobe, `res_valid` is 0, `res_count` is 000 and `res_stack` is 000000.
- R2: Each 3-bit group is sorted into a thermometer stack (ones at the low end) with the same number of ones as the group. When the upper group (bits 5:3) is zero, `res_stack` equals the lower group's stack.
- R3: `res_stack` is a thermometer code. Bit k is 1 exactly when more than k of the captured inputs were 1.
- R4: `res_count` equals the number of ones among the six captured inputs, as an unsigned binary value from 0 to 6.
- R5: `res_count` never shows 111.
- R6: An all-zero input gives count 000 and stack 000000. An all-one input gives count 110 and stack 111111.
- R7: A sample accepted with `smp_valid` high at a rising edge appears on the outputs right after that edge, with `res_valid` high for exactly that cycle.
- R8: When `smp_valid` is low at an edge, `res_count` and `res_stack` keep their previous values, whatever `smp_bits` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Capture strobe for `smp_bits` |
| smp_bits | input | 6 | Six bits to be counted |
| res_valid | output | 1 | High for one cycle when a new result is shown |
| res_count | output | 3 | Number of ones, binary 0..6 |
| res_stack | output | 6 | Merged thermometer stack of the ones |

## Verification
The hardest cases to reach are the lopsided splits of the merge. For example, three ones in one group and none in the other must give the same stack as a two-and-one split. This works only if every AND-OR term of the merge pairs the right stack depths. The stimulus therefore walks all 64 input patterns back to back, which covers every pair of group depths in both orders. Idle cycles with every input bit set follow, to show that the result register holds.

// File: rtl/popcnt6_pkg.sv
package popcnt6_pkg;
  localparam int GRP_W  = 3;
  localparam int NUM_GR = 2;
  localparam int NUM_IN = GRP_W * NUM_GR;
  localparam int CNT_W  = $clog2(NUM_IN + 1);

  typedef logic [GRP_W-1:0]  grp_t;
  typedef logic [NUM_IN-1:0] therm_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/tri_stacker.sv
module tri_stacker
  import popcnt6_pkg::*;
(
  input  grp_t bits,
  output grp_t stk
);
  // stk[0]: at least one, stk[1]: at least two, stk[2]: all three
  always_comb begin
    stk[0] = bits[0] | bits[1] | bits[2];
    stk[1] = (bits[0] & bits[1]) | (bits[1] & bits[2]) | (bits[0] & bits[2]);
    stk[2] = bits[0] & bits[1] & bits[2];
  end

  always_comb begin
    if (!$isunknown(bits)) begin
      assert_group_count_R2: assert ($countones(stk) == $countones(bits));
      assert_group_therm_R2: assert (!(stk[2] & ~stk[1]) && !(stk[1] & ~stk[0]));
    end
  end
endmodule

// File: rtl/stack_merge.sv
module stack_merge #(
  parameter int W = 3
) (
  input  logic [W-1:0]   stk_a,
  input  logic [W-1:0]   stk_b,
  output logic [2*W-1:0] merged
);
  localparam int OW = 2 * W;

  // depth flags: ge_x[i] = "at least i ones", ge_x[0] always true
  logic [W:0] ge_a, ge_b;
  assign ge_a = {stk_a, 1'b1};
  assign ge_b = {stk_b, 1'b1};

  // bit k set when some split i + j = k + 1 is reachable in both stacks
  always_comb begin
    merged = '0;
    for (int k = 0; k < OW; k++) begin
      for (int i = 0; i <= W; i++) begin
        if ((k + 1 - i) >= 0 && (k + 1 - i) <= W)
          merged[k] = merged[k] | (ge_a[i] & ge_b[k + 1 - i]);
      end
    end
  end

  always_comb begin
    if (!$isunknown({stk_a, stk_b})) begin
      assert_merge_count_R3: assert ($countones(merged) == $countones(stk_a) + $countones(stk_b));
      for (int k = 0; k < OW - 1; k++)
        assert_merge_therm_R3: assert (!(merged[k + 1] & ~merged[k]));
    end
  end
endmodule

// File: rtl/therm_to_bin.sv
module therm_to_bin
  import popcnt6_pkg::*;
(
  input  therm_t stk,
  output cnt_t   cnt
);
  always_comb begin
    cnt[2] = stk[3];
    cnt[1] = (stk[1] & ~stk[3]) | stk[5];
    cnt[0] = (stk[0] & ~stk[1]) | (stk[2] & ~stk[3]) | (stk[4] & ~stk[5]);
  end

  always_comb begin
    if (!$isunknown(stk)) begin
      assert_no_seven_R5: assert (cnt != 3'b111);
      assert_bin_value_R4: assert (int'(cnt) == $countones(stk));
    end
  end
endmodule

// File: rtl/popcnt6_core.sv
module popcnt6_core
  import popcnt6_pkg::*;
(
  input  therm_t in_bits,
  output therm_t stack6,
  output cnt_t   count
);
  grp_t grp_stk [NUM_GR];

  for (genvar g = 0; g < NUM_GR; g++) begin : g_grp
    tri_stacker u_stk (
      .bits (in_bits[g*GRP_W +: GRP_W]),
      .stk  (grp_stk[g])
    );
  end

  stack_merge #(.W(GRP_W)) u_merge (
    .stk_a  (grp_stk[0]),
    .stk_b  (grp_stk[1]),
    .merged (stack6)
  );

  therm_to_bin u_bin (
    .stk (stack6),
    .cnt (count)
  );
endmodule

// File: rtl/stack_popcnt6_reg.sv
module stack_popcnt6_reg
  import popcnt6_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_valid,
  input  logic [5:0] smp_bits,
  output logic       res_valid,
  output logic [2:0] res_count,
  output logic [5:0] res_stack
);
  therm_t comb_stack;
  cnt_t   comb_count;

  popcnt6_core u_core (
    .in_bits (smp_bits),
    .stack6  (comb_stack),
    .count   (comb_count)
  );

  // next-state
  logic   nxt_valid;
  cnt_t   nxt_count;
  therm_t nxt_stack;

  always_comb begin
    nxt_valid = smp_valid;
    nxt_count = res_count;
    nxt_stack = res_stack;
    if (smp_valid) begin
      nxt_count = comb_count;
      nxt_stack = comb_stack;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_count <= '0;
      res_stack <= '0;
    end else begin
      res_valid <= nxt_valid;
      res_count <= nxt_count;
      res_stack <= nxt_stack;
    end
  end

  assert_count_matches_stack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_count) == $countones(res_stack)));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_count != 3'b111);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> res_valid);
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(res_count) && $stable(res_stack) && !res_valid));
endmodule

// File: tb/test_stack_popcnt6_reg.sv
`timescale 1ns/1ps
module test_stack_popcnt6_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_valid;
  logic [5:0] smp_bits;
  logic       res_valid;
  logic [2:0] res_count;
  logic [5:0] res_stack;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  stack_popcnt6_reg i_stack_popcnt6_reg (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bits(smp_bits),
    .res_valid(res_valid), .res_count(res_count), .res_stack(res_stack)
  );

  typedef struct packed { logic [5:0] pat; logic [2:0] cnt; logic [5:0] stk; } exp_t;
  exp_t sb_q[$];
  exp_t last_exp;
  bit   seen = 0;

  function automatic exp_t model(input logic [5:0] p);
    exp_t e;
    int n = 0;
    for (int i = 0; i < 6; i++) n += int'(p[i]);
    e.pat = p;
    e.cnt = 3'(n);
    e.stk = '0;
    for (int k = 0; k < 6; k++) e.stk[k] = (n > k);
    return e;
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic drive(input logic [5:0] p);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_bits  = p;
    sb_q.push_back(model(p));
  endtask

  task automatic idle(input logic [5:0] p);
    @(negedge clk);
    smp_valid = 1'b0;
    smp_bits  = p;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (res_valid) begin
        if (sb_q.size() == 0) begin
          check("R7 unexpected valid", 1, 0);
        end else begin
          exp_t e;
          string rc, rs;
          e = sb_q.pop_front();
          rc = (e.pat == 6'h00 || e.pat == 6'h3f) ? "R6 count" : "R4 count";
          rs = (e.pat[5:3] == 3'b000) ? "R2 stack" :
               ((e.pat == 6'h00 || e.pat == 6'h3f) ? "R6 stack" : "R3 stack");
          check(rc, int'(res_count), int'(e.cnt));
          check(rs, int'(res_stack), int'(e.stk));
          check("R5 no 111", int'(res_count == 3'b111), 0);
          last_exp = e;
          seen = 1;
        end
      end else if (seen) begin
        check("R8 hold count", int'(res_count), int'(last_exp.cnt));
        check("R8 hold stack", int'(res_stack), int'(last_exp.stk));
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    smp_valid = 1'b0;
    smp_bits = 6'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(res_valid), 0);
    check("R1 count", int'(res_count), 0);
    check("R1 stack", int'(res_stack), 0);
    rst_n = 1'b1;
    idle(6'h3f);
    @(negedge clk);
    check("R1 idle after reset", int'(res_count), 0);
    // exhaustive walk, back to back
    for (int p = 0; p < 64; p++) drive(6'(p));
    // lopsided splits again, then all ones / zeros
    drive(6'b000111);
    drive(6'b111000);
    drive(6'h3f);
    drive(6'h00);
    drive(6'b101101);
    // R8: idle with all inputs high must not disturb the result
    idle(6'h3f);
    idle(6'h3f);
    idle(6'h12);
    @(negedge clk);
    check("R8 final count", int'(res_count), 4);
    check("R7 queue drained", sb_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule